// File: doc/BRIEF.md
# Step-Down Converter Fault Supervisor

This synchronous block watches the output of a step-down converter and decides whether the high-side and low-side gate drivers may switch. Its inputs are already-digitized comparator flags taken from an output-sense divider. One flag says the output is under 75% of nominal, one says it is over 125%, and one says it has fallen under 50%. An overcurrent flag comes in as well. The block also receives a soft-start-done indication from the ramp logic, an external enable, and a clock-enable tick that paces the overcurrent retry timer. The active-low reset is the power-on reset.

Each fault has its own latch and its own way of being cleared. Undervoltage and overvoltage stay latched until power-on reset, and the external enable cannot release them. Overcurrent is released by the enable. A build parameter selects how overcurrent is handled: it either latches, or it waits a set number of ticks and then asks for a new soft-start, as often as needed. While overvoltage is latched, the block pulses the low-side driver to discharge the output between the 125% and 50% thresholds. A second parameter removes undervoltage protection altogether. Status outputs show which faults are active and which one latched first.

Top module: `buck_guard`

## Requirements
- R1: After power-on reset with the enable high and all flags low, `flt_act` is 0, `first_code` is 0, `hs_en` and `ls_en` are 1, and `ls_force` and `ss_restart` are 0.
- R2: Every comparator flag passes through a two-flop synchronizer. A flag raised before clock edge k has no effect on any output after edge k+1. Its effect appears after edge k+2.
- R3: When undervoltage is sensed after soft-start is done, the undervoltage latch sets. `flt_act[0]` becomes 1, and `hs_en` and `ls_en` become 0.
- R4: The undervoltage flag is ignored while `ss_done` is low.
- R5: Once set, the undervoltage latch (`flt_act[0]`) and the overvoltage latch (`flt_act[1]`) stay set until power-on reset. Toggling `en` does not clear them.
- R6: An overvoltage flag sets the overvoltage latch whether or not soft-start is done. `flt_act[1]` becomes 1, `hs_en` becomes 0, and `ls_force` becomes 1.
- R7: While overvoltage is latched, `ls_force` drops to 0 when the below-half flag is sensed. It returns to 1 whenever the overvoltage flag is sensed again.
- R8: In latching overcurrent mode, a sensed overcurrent sets `flt_act[2]` and forces `hs_en` and `ls_en` to 0. Driving `en` low for one cycle clears it.
- R9: In retry mode, overcurrent holds `flt_act[2]` for RETRY_TICKS ticks. It then clears and pulses `ss_restart` high for exactly one cycle, after which the drives are enabled again.
- R10: While overcurrent is active, the undervoltage flag cannot set its latch. Overvoltage can still set its latch.
- R11: With UV_EN = 0, the undervoltage flag never sets `flt_act[0]`.
- R12: `first_code` names the first latched fault, with 0 = none, 1 = undervoltage, 2 = overvoltage and 3 = overcurrent. It updates one cycle after a latch sets and holds until that fault clears. It then names another active fault, picked in the order overvoltage, overcurrent, undervoltage.
- R13: With `en` low and no fault, `hs_en` and `ls_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| en | input | 1 | External enable |
| tick | input | 1 | Clock enable that paces the retry timer |
| ss_done | input | 1 | Soft-start ramp finished |
| uv_raw | input | 1 | Output below 75% of nominal |
| ov_raw | input | 1 | Output above 125% of nominal |
| half_raw | input | 1 | Output below 50% of nominal |
| oc_raw | input | 1 | Overcurrent detected |
| hs_en | output | 1 | High-side driver may switch |
| ls_en | output | 1 | Low-side driver may switch |
| ls_force | output | 1 | Low-side driver held on for discharge |
| ss_restart | output | 1 | One-cycle request for a new soft-start |
| flt_act | output | 3 | Active faults: bit0 undervoltage, bit1 overvoltage, bit2 overcurrent |
| first_code | output | 2 | Code of the first latched fault |

## Verification
On every cycle, the assertions check the following:
- the undervoltage and overvoltage latches never fall while reset is released;
- the high-side enable is never up while overvoltage is active;
- discharge forcing only ever happens under an overvoltage latch;
- the restart request never lasts more than one cycle;
- a first-fault code of undervoltage or overvoltage never changes.

Only the bench scenarios can show the rest. This covers the exact synchronizer latency, that undervoltage is gated by soft-start and by overcurrent, and that discharge pulses back on when overvoltage returns. It also covers the retry wait length, the release of a latched overcurrent by the enable, and how the first-fault code hands over when overcurrent clears.

// File: rtl/buck_guard_pkg.sv
package buck_guard_pkg;
  localparam int NFLAG = 4;
  localparam int IX_UV   = 0;
  localparam int IX_OV   = 1;
  localparam int IX_HALF = 2;
  localparam int IX_OC   = 3;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_UV   = 2'd1,
    FC_OV   = 2'd2,
    FC_OC   = 2'd3
  } fault_code_t;

  typedef enum logic {
    OCS_RUN  = 1'b0,
    OCS_HOLD = 1'b1
  } oc_state_t;
endpackage

// File: rtl/buck_flag_sync.sv
module buck_flag_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end
endmodule

// File: rtl/buck_ov_discharge.sv
module buck_ov_discharge (
  input  logic clk,
  input  logic rst_n,
  input  logic ov_s,
  input  logic half_s,
  output logic ov_lat,
  output logic dis_on
);
  logic lat_q, lat_n;
  logic dis_q, dis_n;

  always_comb begin
    lat_n = lat_q;
    dis_n = dis_q;
    if (ov_s) begin
      lat_n = 1'b1;
      dis_n = 1'b1;
    end else if (lat_q && half_s) begin
      dis_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
      dis_q <= 1'b0;
    end else begin
      lat_q <= lat_n;
      dis_q <= dis_n;
    end
  end

  assign ov_lat = lat_q;
  assign dis_on = lat_q & dis_q;
endmodule

// File: rtl/buck_oc_ctrl.sv
module buck_oc_ctrl
  import buck_guard_pkg::*;
#(
  parameter bit RETRY       = 1'b0,
  parameter int RETRY_TICKS = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic oc_s,
  output logic oc_act,
  output logic restart
);
  localparam int CW = $clog2(RETRY_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(RETRY_TICKS - 1);

  oc_state_t     st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          rs_q, rs_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    rs_n  = 1'b0;
    if (!en) begin
      st_n  = OCS_RUN;
      cnt_n = '0;
    end else begin
      case (st_q)
        OCS_RUN: begin
          if (oc_s) begin
            st_n  = OCS_HOLD;
            cnt_n = '0;
          end
        end
        default: begin
          if (tick) begin
            if (cnt_q == LAST) begin
              if (RETRY) begin
                st_n  = OCS_RUN;
                rs_n  = 1'b1;
                cnt_n = '0;
              end
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= OCS_RUN;
      cnt_q <= '0;
      rs_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      rs_q  <= rs_n;
    end
  end

  assign oc_act  = (st_q == OCS_HOLD);
  assign restart = rs_q;
endmodule

// File: rtl/buck_guard.sv
module buck_guard
  import buck_guard_pkg::*;
#(
  parameter bit UV_EN       = 1'b1,
  parameter bit OC_RETRY    = 1'b0,
  parameter int RETRY_TICKS = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       ss_done,
  input  logic       uv_raw,
  input  logic       ov_raw,
  input  logic       half_raw,
  input  logic       oc_raw,
  output logic       hs_en,
  output logic       ls_en,
  output logic       ls_force,
  output logic       ss_restart,
  output logic [2:0] flt_act,
  output logic [1:0] first_code
);
  logic [NFLAG-1:0] raw_v, syn_v;
  logic ov_lat, dis_on, oc_act;
  logic uv_q, uv_n;
  fault_code_t code_q, code_n;
  logic sw_ok;

  always_comb begin
    raw_v          = '0;
    raw_v[IX_UV]   = uv_raw;
    raw_v[IX_OV]   = ov_raw;
    raw_v[IX_HALF] = half_raw;
    raw_v[IX_OC]   = oc_raw;
  end

  buck_flag_sync #(.W(NFLAG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v)
  );

  buck_ov_discharge u_ov (
    .clk(clk), .rst_n(rst_n),
    .ov_s(syn_v[IX_OV]), .half_s(syn_v[IX_HALF]),
    .ov_lat(ov_lat), .dis_on(dis_on)
  );

  buck_oc_ctrl #(.RETRY(OC_RETRY), .RETRY_TICKS(RETRY_TICKS)) u_oc (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
    .oc_s(syn_v[IX_OC]), .oc_act(oc_act), .restart(ss_restart)
  );

  // Undervoltage latch: armed after soft-start, blocked by active overcurrent
  always_comb begin
    uv_n = uv_q;
    if (UV_EN && syn_v[IX_UV] && ss_done && !oc_act)
      uv_n = 1'b1;
  end

  // First-fault record
  always_comb begin
    code_n = code_q;
    if (code_q == FC_OC && !oc_act)
      code_n = FC_NONE;
    if (code_n == FC_NONE) begin
      if (ov_lat)      code_n = FC_OV;
      else if (oc_act) code_n = FC_OC;
      else if (uv_q)   code_n = FC_UV;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q   <= 1'b0;
      code_q <= FC_NONE;
    end else begin
      uv_q   <= uv_n;
      code_q <= code_n;
    end
  end

  assign sw_ok      = en & ~uv_q & ~ov_lat & ~oc_act;
  assign hs_en      = sw_ok;
  assign ls_en      = sw_ok;
  assign ls_force   = dis_on;
  assign flt_act    = {oc_act, ov_lat, uv_q};
  assign first_code = code_q;
endmodule

// File: rtl/buck_guard_chk.sv
module buck_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hs_en,
  input logic       ls_force,
  input logic       ss_restart,
  input logic [2:0] flt_act,
  input logic [1:0] first_code
);
  // R5: undervoltage latch never falls without reset
  assert_uv_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flt_act[0] |=> flt_act[0]);

  // R5: overvoltage latch never falls without reset
  assert_ov_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flt_act[1] |=> flt_act[1]);

  // R6: high side never enabled with overvoltage latched
  assert_ov_blocks_hs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_act[1] |-> !hs_en);

  // R7: discharge forcing only under overvoltage latch
  assert_force_needs_ov_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ls_force |-> flt_act[1]);

  // R9: restart request is a single-cycle pulse
  assert_restart_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart);

  // R12: a voltage-fault first code is held
  assert_code_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (first_code == 2'd1 || first_code == 2'd2) |=> $stable(first_code));
endmodule

bind buck_guard buck_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .ls_force(ls_force),
  .ss_restart(ss_restart), .flt_act(flt_act), .first_code(first_code)
);

// File: tb/sim_buck_guard.sv
module sim_buck_guard;
  localparam int NT = 8;

  logic clk, rst_n, en, tick, ss_done;
  logic uv_raw, ov_raw, half_raw, oc_raw;
  logic a_hs, a_ls, a_lf, a_rs, b_hs, b_ls, b_lf, b_rs;
  logic [2:0] a_flt, b_flt;
  logic [1:0] a_code, b_code;
  int tests, fails;
  bit done;

  // u0: latching overcurrent, undervoltage protection on
  buck_guard #(.UV_EN(1'b1), .OC_RETRY(1'b0), .RETRY_TICKS(NT)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .ss_done(ss_done),
    .uv_raw(uv_raw), .ov_raw(ov_raw), .half_raw(half_raw), .oc_raw(oc_raw),
    .hs_en(a_hs), .ls_en(a_ls), .ls_force(a_lf), .ss_restart(a_rs),
    .flt_act(a_flt), .first_code(a_code));

  // u1: retry overcurrent, undervoltage protection off
  buck_guard #(.UV_EN(1'b0), .OC_RETRY(1'b1), .RETRY_TICKS(NT)) u1 (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .ss_done(ss_done),
    .uv_raw(uv_raw), .ov_raw(ov_raw), .half_raw(half_raw), .oc_raw(oc_raw),
    .hs_en(b_hs), .ls_en(b_ls), .ls_force(b_lf), .ss_restart(b_rs),
    .flt_act(b_flt), .first_code(b_code));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b1; tick = 1'b1; ss_done = 1'b0;
    uv_raw = 1'b0; ov_raw = 1'b0; half_raw = 1'b0; oc_raw = 1'b0;
    edges(2);
    rst_n = 1'b1;
    edges(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 flt", int'(a_flt), 0);
    chk("R1 code", int'(a_code), 0);
    chk("R1 drives", int'({a_hs, a_ls, a_lf, a_rs}), 4'b1100);
    chk("R1 drives u1", int'({b_hs, b_ls, b_lf, b_rs}), 4'b1100);
  endtask

  task automatic t_enable();
    do_reset();
    en = 1'b0;
    edges(1);
    chk("R13 en low", int'({a_hs, a_ls, b_hs, b_ls}), 0);
    en = 1'b1;
    edges(1);
    chk("R13 en high", int'({a_hs, a_ls}), 2'b11);
  endtask

  task automatic t_uv();
    do_reset();
    uv_raw = 1'b1;
    edges(5);
    chk("R4 uv before ss", int'(a_flt), 0);
    ss_done = 1'b1;
    edges(1);
    chk("R3 uv latch", int'(a_flt), 1);
    chk("R3 drives off", int'({a_hs, a_ls}), 0);
    chk("R11 uv disabled", int'({b_flt[0], b_hs}), 2'b01);
    edges(1);
    chk("R12 code uv", int'(a_code), 1);
    uv_raw = 1'b0;
    en = 1'b0;
    edges(2);
    en = 1'b1;
    edges(3);
    chk("R5 uv after en toggle", int'(a_flt[0]), 1);
  endtask

  task automatic t_sync();
    do_reset();
    ss_done = 1'b1;
    uv_raw = 1'b1;
    edges(2);
    chk("R2 not yet", int'(a_flt[0]), 0);
    edges(1);
    chk("R2 R3 visible", int'(a_flt[0]), 1);
  endtask

  task automatic t_ov();
    do_reset();
    ov_raw = 1'b1;
    edges(3);
    chk("R6 ov latch", int'({a_flt[1], a_hs, a_lf}), 3'b101);
    chk("R6 ov u1", int'({b_flt[1], b_hs, b_lf}), 3'b101);
    ov_raw = 1'b0;
    half_raw = 1'b1;
    edges(3);
    chk("R7 release", int'(a_lf), 0);
    half_raw = 1'b0;
    ov_raw = 1'b1;
    edges(3);
    chk("R7 reassert", int'(a_lf), 1);
    ov_raw = 1'b0;
    en = 1'b0;
    edges(2);
    en = 1'b1;
    edges(2);
    chk("R5 ov after en toggle", int'(a_flt[1]), 1);
    chk("R12 code ov", int'(a_code), 2);
  endtask

  task automatic t_oc_latch();
    do_reset();
    ss_done = 1'b1;
    oc_raw = 1'b1;
    edges(3);
    chk("R8 oc latch", int'({a_flt[2], a_hs, a_ls}), 3'b100);
    oc_raw = 1'b0;
    uv_raw = 1'b1;
    edges(5);
    chk("R10 uv blocked", int'(a_flt[0]), 0);
    uv_raw = 1'b0;
    ov_raw = 1'b1;
    edges(3);
    chk("R10 ov still", int'(a_flt[1]), 1);
    chk("R12 code oc first", int'(a_code), 3);
    ov_raw = 1'b0;
    edges(3);
    chk("R8 oc held", int'(a_flt[2]), 1);
    en = 1'b0;
    edges(1);
    en = 1'b1;
    chk("R8 oc cleared", int'(a_flt[2]), 0);
    edges(1);
    chk("R12 code hand over", int'(a_code), 2);
  endtask

  task automatic t_oc_retry();
    do_reset();
    ss_done = 1'b1;
    oc_raw = 1'b1;
    edges(3);
    chk("R9 oc active", int'({b_flt[2], b_hs, b_rs}), 3'b100);
    oc_raw = 1'b0;
    edges(NT - 1);
    chk("R9 still waiting", int'({b_flt[2], b_rs}), 2'b10);
    edges(1);
    chk("R9 restart", int'({b_flt[2], b_rs, b_hs}), 3'b011);
    edges(1);
    chk("R9 pulse one cycle", int'(b_rs), 0);
  endtask

  initial begin
    tests = 0; fails = 0; done = 1'b0;
    t_reset();
    t_enable();
    t_uv();
    t_sync();
    t_ov();
    t_oc_latch();
    t_oc_retry();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule